// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address while paging is switched on. For each accepted request it fetches a page directory entry and, unless that entry maps a 4 MB page, a page table entry. Both come through a single 32-bit read port that holds its request until the memory answers. The block checks presence and access rights on the way. It then returns either the physical address or a fault with a three-bit error code and the linear address that caused it.

With paging switched off the block answers one cycle after acceptance, passes the linear address through unchanged and issues no memory read. The paging switch and the directory base are captured when a request is accepted. The block handles one translation at a time. Its caller is normally a TLB-miss path that waits for the single-cycle response pulse.

Top module: `lin2phys_walker`

## Requirements
- R1: With `paging_on` low at acceptance, `resp_valid` pulses in the next cycle with `resp_phys` equal to the linear address, no fault and no memory read.
- R2: The first read of a walk targets the directory base frame (base bits 31:12) joined with linear bits 31:22 as a word index, so the address is {base[31:12], lin[31:22], 2'b00}.
- R3: When the directory entry is present and its bit 7 is clear, the second read targets {pde[31:12], lin[21:12], 2'b00}. A successful walk returns {pte[31:12], lin[11:0]}.
- R4: A clear bit 0 in the directory entry or the table entry gives a fault with error bit 0 = 0. An absent directory entry ends the walk without a second read.
- R5: A present directory entry with bit 7 set ends the walk after one read and returns {pde[31:22], lin[21:0]}. Directory bits 21:12 are ignored.
- R6: A user access (`req_cpl` not 0) faults unless bit 2 (user allowed) is set in both the directory entry and the table entry.
- R7: A user write faults unless bit 1 (writable) is set in both entries. A user read ignores bit 1.
- R8: A supervisor access (`req_cpl` = 0) never faults on rights. It faults only on a missing entry, even when writing to a read-only or supervisor-only page.
- R9: On a fault the error code is {user, write, present} with present in bit 0. `resp_fault_lin` holds the linear address and `resp_phys` reads 0. Without a fault, the error code and `resp_fault_lin` read 0.
- R10: `req_ready` is high only when the block is idle. `resp_valid` lasts exactly one cycle. `mem_rd_req` stays high with a stable address until `mem_rd_valid`.
- R11: For a 4 MB page the rights come from the directory entry alone, using the same rules as R6 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| paging_on | input | 1 | Translation enable, captured at acceptance |
| dir_base | input | 32 | Directory base address, bits 31:12 used, captured at acceptance |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle and able to accept |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_cpl | input | 2 | Current privilege level, 0 = supervisor |
| mem_rd_req | output | 1 | Entry read request, held until served |
| mem_rd_addr | output | 32 | Entry byte address |
| mem_rd_valid | input | 1 | Read data valid, ends the held request |
| mem_rd_data | input | 32 | Entry read data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_fault | output | 1 | Page fault |
| resp_phys | output | 32 | Physical address, 0 on fault |
| resp_err_code | output | 3 | {user, write, present} on fault |
| resp_fault_lin | output | 32 | Faulting linear address |

## Verification
The hardest case to reach from the ports is a mismatch in rights between the two levels. An example is a directory entry that allows user writes over a table entry that forbids them, or the reverse, combined with each privilege and direction and with the directory's 4 MB flag. The bench reaches every such case by rewriting the two entries in its memory model before each request. It sweeps all eight flag patterns of each level against user/supervisor and read/write. The memory latency rotates, so that held read requests are checked against the walk step the model expects on every cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W      = 32;
  localparam int DIR_IDX_W = 10;
  localparam int TBL_IDX_W = 10;
  localparam int OFS_W     = 12;
  localparam int ENT_LOG   = 2;
  localparam int FRAME_W   = VA_W - OFS_W;
  localparam int BIG_OFS_W = TBL_IDX_W + OFS_W;
  localparam int BIG_FRM_W = VA_W - BIG_OFS_W;
  localparam int CODE_W    = 3;

  localparam int BIT_PRESENT  = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_USER     = 2;
  localparam int BIT_BIGPAGE  = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_DIR, ST_TBL, ST_RESP} walk_state_t;

  function automatic logic [VA_W-1:0] dir_entry_addr(input logic [FRAME_W-1:0] base_frame,
                                                      input logic [VA_W-1:0] lin);
    return {base_frame, lin[VA_W-1 -: DIR_IDX_W], {ENT_LOG{1'b0}}};
  endfunction

  function automatic logic [VA_W-1:0] tbl_entry_addr(input logic [VA_W-1:0] pde,
                                                      input logic [VA_W-1:0] lin);
    return {pde[VA_W-1 -: FRAME_W], lin[OFS_W +: TBL_IDX_W], {ENT_LOG{1'b0}}};
  endfunction

  function automatic logic [VA_W-1:0] phys_small(input logic [VA_W-1:0] pte,
                                                  input logic [VA_W-1:0] lin);
    return {pte[VA_W-1 -: FRAME_W], lin[OFS_W-1:0]};
  endfunction

  function automatic logic [VA_W-1:0] phys_big(input logic [VA_W-1:0] pde,
                                                input logic [VA_W-1:0] lin);
    return {pde[VA_W-1 -: BIG_FRM_W], lin[BIG_OFS_W-1:0]};
  endfunction

  function automatic logic [CODE_W-1:0] fault_code(input logic present, input logic write,
                                                    input logic user);
    return {user, write, present};
  endfunction
endpackage

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0] pde,
  input  logic [VA_W-1:0] pte,
  input  logic            use_tbl,
  input  logic            is_user,
  input  logic            is_write,
  output logic            present_ok,
  output logic            access_ok
);
  logic eff_wr;
  logic eff_us;

  always_comb begin
    present_ok = pde[BIT_PRESENT] & (~use_tbl | pte[BIT_PRESENT]);
    eff_wr     = pde[BIT_WRITABLE] & (~use_tbl | pte[BIT_WRITABLE]);
    eff_us     = pde[BIT_USER] & (~use_tbl | pte[BIT_USER]);
    // supervisor passes regardless of the writable and user bits
    access_ok  = ~is_user | (eff_us & (~is_write | eff_wr));
  end
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              paging_on,
  input  logic [VA_W-1:0]   dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_lin,
  input  logic              req_write,
  input  logic              req_user,
  output logic              mem_rd_req,
  output logic [VA_W-1:0]   mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [VA_W-1:0]   mem_rd_data,
  output logic [VA_W-1:0]   chk_pde,
  output logic [VA_W-1:0]   chk_pte,
  output logic              chk_use_tbl,
  output logic              chk_user,
  output logic              chk_write,
  input  logic              present_ok,
  input  logic              access_ok,
  output logic              done,
  output logic              done_fault,
  output logic [VA_W-1:0]   done_phys,
  output logic [CODE_W-1:0] done_code,
  output logic [VA_W-1:0]   done_lin
);
  walk_state_t        state_q, state_d;
  logic [VA_W-1:0]    lin_q, pde_q;
  logic [FRAME_W-1:0] base_q;
  logic               wr_q, usr_q;

  // named walk events
  logic walk_start, bypass_hit, dir_done, dir_absent, dir_big, dir_descend, tbl_done;

  always_comb begin
    walk_start  = (state_q == ST_IDLE) & req_valid & paging_on;
    bypass_hit  = (state_q == ST_IDLE) & req_valid & ~paging_on;
    dir_done    = (state_q == ST_DIR) & mem_rd_valid;
    dir_absent  = dir_done & ~present_ok;
    dir_big     = dir_done & present_ok & mem_rd_data[BIT_BIGPAGE];
    dir_descend = dir_done & present_ok & ~mem_rd_data[BIT_BIGPAGE];
    tbl_done    = (state_q == ST_TBL) & mem_rd_valid;
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign mem_rd_req  = (state_q == ST_DIR) | (state_q == ST_TBL);
  assign mem_rd_addr = (state_q == ST_TBL) ? tbl_entry_addr(pde_q, lin_q)
                                           : dir_entry_addr(base_q, lin_q);

  assign chk_use_tbl = (state_q == ST_TBL);
  assign chk_pde     = chk_use_tbl ? pde_q : mem_rd_data;
  assign chk_pte     = mem_rd_data;
  assign chk_user    = usr_q;
  assign chk_write   = wr_q;

  always_comb begin
    done       = bypass_hit | dir_absent | dir_big | tbl_done;
    done_fault = dir_absent | ((dir_big | tbl_done) & ~(present_ok & access_ok));
    done_lin   = bypass_hit ? req_lin : lin_q;
    if (bypass_hit)   done_phys = req_lin;
    else if (dir_big) done_phys = phys_big(mem_rd_data, lin_q);
    else              done_phys = phys_small(mem_rd_data, lin_q);
    done_code  = fault_code((dir_big | tbl_done) & present_ok, wr_q, usr_q);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (walk_start) state_d = ST_DIR;
               else if (bypass_hit) state_d = ST_RESP;
      ST_DIR:  if (dir_descend) state_d = ST_TBL;
               else if (dir_done) state_d = ST_RESP;
      ST_TBL:  if (tbl_done) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lin_q   <= '0;
      pde_q   <= '0;
      base_q  <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (walk_start) begin
        lin_q  <= req_lin;
        base_q <= dir_base[VA_W-1 -: FRAME_W];
        wr_q   <= req_write;
        usr_q  <= req_user;
      end
      if (dir_descend) pde_q <= mem_rd_data;
    end
  end

  assert_hold_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
  assert_walk_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> (mem_rd_req && mem_rd_addr[ENT_LOG-1:0] == '0));
  assert_absent_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dir_absent |=> !mem_rd_req);
  assert_big_one_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dir_big |=> !mem_rd_req);
  assert_descend_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dir_descend |=> mem_rd_req);
endmodule

// File: rtl/ptw_resp_stage.sv
module ptw_resp_stage
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              done_fault,
  input  logic [VA_W-1:0]   done_phys,
  input  logic [CODE_W-1:0] done_code,
  input  logic [VA_W-1:0]   done_lin,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [VA_W-1:0]   resp_phys,
  output logic [CODE_W-1:0] resp_err_code,
  output logic [VA_W-1:0]   resp_fault_lin
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid     <= 1'b0;
      resp_fault     <= 1'b0;
      resp_phys      <= '0;
      resp_err_code  <= '0;
      resp_fault_lin <= '0;
    end else begin
      resp_valid <= done;
      if (done) begin
        resp_fault     <= done_fault;
        resp_phys      <= done_fault ? '0 : done_phys;
        resp_err_code  <= done_fault ? done_code : '0;
        resp_fault_lin <= done_fault ? done_lin : '0;
      end
    end
  end

  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  assert_super_only_absent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault && !resp_err_code[2]) |-> !resp_err_code[0]);
endmodule

// File: rtl/lin2phys_walker.sv
module lin2phys_walker
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        paging_on,
  input  logic [31:0] dir_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin,
  input  logic        req_write,
  input  logic [1:0]  req_cpl,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        resp_valid,
  output logic        resp_fault,
  output logic [31:0] resp_phys,
  output logic [2:0]  resp_err_code,
  output logic [31:0] resp_fault_lin
);
  logic [VA_W-1:0]   chk_pde, chk_pte, done_phys, done_lin;
  logic              chk_use_tbl, chk_user, chk_write, present_ok, access_ok;
  logic              done, done_fault;
  logic [CODE_W-1:0] done_code;
  logic              req_user;

  assign req_user = (req_cpl != 2'd0);

  ptw_perm_check u_perm (
    .pde(chk_pde), .pte(chk_pte), .use_tbl(chk_use_tbl),
    .is_user(chk_user), .is_write(chk_write),
    .present_ok(present_ok), .access_ok(access_ok)
  );

  ptw_walk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .paging_on(paging_on), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .chk_pde(chk_pde), .chk_pte(chk_pte), .chk_use_tbl(chk_use_tbl),
    .chk_user(chk_user), .chk_write(chk_write),
    .present_ok(present_ok), .access_ok(access_ok),
    .done(done), .done_fault(done_fault), .done_phys(done_phys),
    .done_code(done_code), .done_lin(done_lin)
  );

  ptw_resp_stage u_resp (
    .clk(clk), .rst_n(rst_n), .done(done), .done_fault(done_fault),
    .done_phys(done_phys), .done_code(done_code), .done_lin(done_lin),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_phys(resp_phys),
    .resp_err_code(resp_err_code), .resp_fault_lin(resp_fault_lin)
  );

  assert_bypass_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !paging_on) |=> (resp_valid && !resp_fault && !mem_rd_req));
  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || resp_valid) |-> !req_ready);
endmodule

// File: tb/lin2phys_walker_tb.sv
module lin2phys_walker_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        paging_on = 0;
  logic [31:0] dir_base = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_lin = 0;
  logic        req_write = 0;
  logic [1:0]  req_cpl = 0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 0;
  logic [31:0] mem_rd_data = 0;
  logic        resp_valid, resp_fault;
  logic [31:0] resp_phys, resp_fault_lin;
  logic [2:0]  resp_err_code;

  int checks = 0;
  int fails = 0;
  int mem_lat = 0;
  bit finished = 0;
  logic [31:0] mem_words [logic [31:0]];

  always #5 clk = ~clk;

  lin2phys_walker u_dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem_words.exists(a)) return mem_words[a];
    return 32'h0;
  endfunction

  // memory responder
  initial begin
    int wait_cnt = 0;
    forever begin
      @(posedge clk);
      if (mem_rd_req && !mem_rd_valid) begin
        if (wait_cnt >= mem_lat) begin
          mem_rd_valid <= 1'b1;
          mem_rd_data  <= rd(mem_rd_addr);
          wait_cnt = 0;
        end else wait_cnt++;
      end else mem_rd_valid <= 1'b0;
    end
  end

  // one translation against the behavioural model
  task automatic translate(input logic [31:0] lin, input bit wr, input logic [1:0] cpl,
                           input bit pg);
    logic [31:0] exp_addr[$];
    logic [31:0] pde, pte, exp_phys, a1, a2;
    bit exp_fault, user, pres;
    string tag;
    int step, cyc;
    user = (cpl != 0);
    exp_fault = 0; pres = 0; exp_phys = 0; tag = "R3";
    if (!pg) begin
      exp_phys = lin; tag = "R1";
    end else begin
      a1 = {dir_base[31:12], 12'h0} + 32'(lin[31:22]) * 4;
      exp_addr.push_back(a1);
      pde = rd(a1);
      if (!pde[0]) begin
        exp_fault = 1; tag = "R4";
      end else if (pde[7]) begin
        pres = 1; tag = "R5";
        if (user && (!pde[2] || (wr && !pde[1]))) begin exp_fault = 1; tag = "R11"; end
        else exp_phys = {pde[31:22], 22'h0} | (lin & 32'h003F_FFFF);
      end else begin
        a2 = {pde[31:12], 12'h0} + 32'(lin[21:12]) * 4;
        exp_addr.push_back(a2);
        pte = rd(a2);
        if (!pte[0]) begin exp_fault = 1; tag = "R4"; end
        else begin
          pres = 1;
          if (user && !(pde[2] && pte[2])) begin exp_fault = 1; tag = "R6"; end
          else if (user && wr && !(pde[1] && pte[1])) begin exp_fault = 1; tag = "R7"; end
          else begin
            exp_phys = {pte[31:12], lin[11:0]};
            tag = user ? "R3" : "R8";
          end
        end
      end
    end
    @(negedge clk);
    chk(req_ready === 1'b1, "R10", "ready when idle", 32'(req_ready), 1);
    req_valid = 1; req_lin = lin; req_write = wr; req_cpl = cpl; paging_on = pg;
    step = 0; cyc = 0;
    forever begin
      @(negedge clk);
      req_valid = 0;
      cyc++;
      if (mem_rd_req) begin
        if (step < exp_addr.size())
          chk(mem_rd_addr === exp_addr[step], step == 0 ? "R2" : "R3", "read address",
              mem_rd_addr, exp_addr[step]);
        else chk(0, "R4", "unexpected read", mem_rd_addr, 0);
        if (mem_rd_valid) step++;
      end
      if (resp_valid || cyc > 60) break;
    end
    chk(resp_valid === 1'b1, tag, "response arrived", 32'(resp_valid), 1);
    if (!pg) chk(cyc == 1, "R1", "bypass latency", cyc, 1);
    chk(step == exp_addr.size(), "R5", "read count", step, exp_addr.size());
    chk(resp_fault === exp_fault, tag, "fault flag", 32'(resp_fault), 32'(exp_fault));
    chk(resp_phys === exp_phys, tag, "physical address", resp_phys, exp_phys);
    chk(resp_err_code === (exp_fault ? {user, wr, pres} : 3'b000), "R9", "error code",
        32'(resp_err_code), 32'(exp_fault ? {user, wr, pres} : 3'b000));
    chk(resp_fault_lin === (exp_fault ? lin : 32'h0), "R9", "fault address",
        resp_fault_lin, exp_fault ? lin : 32'h0);
    @(negedge clk);
    chk(resp_valid === 1'b0, "R10", "single-cycle response", 32'(resp_valid), 0);
  endtask

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && resp_valid === 1'b0 && mem_rd_req === 1'b0, "R10",
        "reset state", {29'h0, req_ready, resp_valid, mem_rd_req}, 32'h4);
    rst_n = 1;
    // passthrough
    translate(32'hDEAD_BEEF, 0, 2'd0, 0);
    translate(32'h0040_3123, 1, 2'd3, 0);
    dir_base = 32'h0010_0ABC;
    // small pages: every flag pattern of both levels
    for (int pf = 0; pf < 8; pf++)
      for (int tf = 0; tf < 8; tf++)
        for (int u = 0; u < 2; u++)
          for (int w = 0; w < 2; w++) begin
            mem_words[32'h0010_0004] = 32'h0020_0000 | 32'(pf);
            mem_words[32'h0020_000C] = 32'h0ABC_D000 | 32'(tf);
            mem_lat = n % 4; n++;
            translate(32'h0040_3123, w[0], u[0] ? ((n % 2) ? 2'd3 : 2'd1) : 2'd0, 1);
          end
    // 4 MB pages with junk in the ignored directory bits
    for (int pf = 0; pf < 8; pf++)
      for (int u = 0; u < 2; u++)
        for (int w = 0; w < 2; w++) begin
          mem_words[32'h0010_0008] = 32'h0C8A_B080 | 32'(pf);
          mem_lat = n % 4; n++;
          translate(32'h0080_5678, w[0], u[0] ? 2'd2 : 2'd0, 1);
        end
    // second directory base
    dir_base = 32'h0030_0000;
    mem_words[32'h0030_0FFC] = 32'h0050_0007;
    mem_words[32'h0050_0FFC] = 32'h1234_5003;
    translate(32'hFFFF_FABC, 1, 2'd0, 1);
    translate(32'hFFFF_FABC, 0, 2'd3, 1);
    translate(32'h1234_5678, 0, 2'd0, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule